// File: doc/BRIEF.md
# Board Power-Up Sequencer

This controller brings up a board with several switched supply rails in a fixed order. It is active as soon as input power is present and its reset is released. Every switched rail stays off until the power button is pressed. After a debounced press, all rails are enabled at once and the controller waits for each rail's power-good input. When every rail reports good, a flash power-up delay runs. Once that delay has elapsed, the FPGA reset is released. When the FPGA raises its configuration-done signal, the main microcontroller is enabled.

A front-panel enable follows the power-good of one chosen rail, for example the 3.3 V rail. It does not wait for the FPGA. If any power-good drops after bring-up, the FPGA goes back into reset and the MCU is disabled, while the rails stay on. If power-good or configuration-done does not arrive within its timeout, the controller turns every rail off and latches a fault until its own reset.

States and transitions:
- OFF (0) goes to RAMP on a press.
- RAMP (1) goes to FLASH when all rails are good, or to FAULT on the power-good timeout.
- FLASH (2) goes to CONFIG after the delay, or back to RAMP if any rail drops.
- CONFIG (3) goes to RUN on done, to RAMP if any rail drops, or to FAULT on the done timeout.
- RUN (4) goes to RAMP if any rail drops.
- FAULT (5) is terminal.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, all rails are off, `fpga_rst_n`, `mcu_en`, `fp_en` and `fault` are low, and `state_o` is 0 (OFF). The state codes are OFF=0, RAMP=1, FLASH=2, CONFIG=3, RUN=4, FAULT=5.
- R2: The button is passed through a 2-flop synchronizer. A press counts only after the synchronized level has been high for DEB_CYC consecutive cycles. Shorter pulses leave the state at OFF.
- R3: A counted press in OFF enables every rail and enters RAMP DEB_CYC+2 cycles after the raw button rises.
- R4: `fp_en` is high when the rails are on and the synchronized power-good of rail FP_IDX is high. It responds 2 cycles after that input changes.
- R5: When all power-goods are high in RAMP, the controller enters FLASH 3 cycles later. It stays in FLASH for exactly `flash_delay` cycles (0 acts as 1), then enters CONFIG and raises `fpga_rst_n`.
- R6: A high `fpga_done` in CONFIG enters RUN and raises `mcu_en` 3 cycles later.
- R7: A power-good drop in FLASH, CONFIG or RUN returns the controller to RAMP 3 cycles later. `fpga_rst_n` and `mcu_en` go low there, and the rails stay on.
- R8: If RAMP lasts PG_TMO cycles without all power-goods, the controller enters FAULT. FAULT turns all rails off and sets `fault`. It holds until reset, and button presses have no effect.
- R9: If CONFIG lasts DONE_TMO cycles without `fpga_done`, the controller enters FAULT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| btn_raw | input | 1 | Raw power button, active high |
| rail_pg | input | N_RAILS | Per-rail power-good, asynchronous |
| fpga_done | input | 1 | FPGA configuration done, asynchronous |
| flash_delay | input | DLY_W | Flash power-up delay in cycles |
| rail_en | output | N_RAILS | Per-rail enable |
| fp_en | output | 1 | Front-panel controller enable |
| fpga_rst_n | output | 1 | FPGA reset, active low |
| mcu_en | output | 1 | Main MCU enable |
| fault | output | 1 | Latched sequencing fault |
| state_o | output | 3 | Current state code |

## Verification
Every asynchronous input passes through two flops and then the state register, so state-driven outputs change 3 cycles after an input is driven. `fp_en` is combinational on the synchronized power-good, so it changes after 2 cycles. The bench drives inputs on falling edges and samples one cycle before and exactly at each due edge. It does this for:
- the debounced press (DEB_CYC+2 cycles),
- every flash delay from 0 to 6,
- both timeouts, measured from the edge the waiting state was entered.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_RAMP   = 3'd1,
        ST_FLASH  = 3'd2,
        ST_CONFIG = 3'd3,
        ST_RUN    = 3'd4,
        ST_FAULT  = 3'd5
    } seq_state_t;
endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] sh_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= 2'b00;
            else        sh_q <= {sh_q[0], d[i]};
        end
        assign q[i] = sh_q[1];
    end
endmodule

// File: rtl/pwr_seq_debounce.sv
module pwr_seq_debounce #(
    parameter int CYC = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic press
);
    localparam int CW = ($clog2(CYC) < 1) ? 1 : $clog2(CYC);
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    logic          level_q;
    logic [CW-1:0] cnt_q;
    logic          diff;
    logic          hit;

    assign diff  = din != level_q;
    assign hit   = cnt_q == LAST;
    assign press = diff && hit && din;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            cnt_q   <= '0;
        end else if (!diff) begin
            cnt_q   <= '0;
        end else if (hit) begin
            level_q <= din;
            cnt_q   <= '0;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // R2: the accepted level only moves after a full qualification window
    a_r2_level_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_q) |-> $past(cnt_q) == LAST);
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (restart)    cnt <= '0;
        else if (cnt != '1)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int N_RAILS  = 4,
    parameter int FP_IDX   = 0,
    parameter int DEB_CYC  = 1_000_000,
    parameter int PG_TMO   = 5_000_000,
    parameter int DONE_TMO = 50_000_000,
    parameter int DLY_W    = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               btn_raw,
    input  logic [N_RAILS-1:0] rail_pg,
    input  logic               fpga_done,
    input  logic [DLY_W-1:0]   flash_delay,
    output logic [N_RAILS-1:0] rail_en,
    output logic               fp_en,
    output logic               fpga_rst_n,
    output logic               mcu_en,
    output logic               fault,
    output logic [2:0]         state_o
);
    localparam int PW = $clog2(PG_TMO + 1);
    localparam int DW = $clog2(DONE_TMO + 1);
    localparam int M1 = (PW > DW) ? PW : DW;
    localparam int TW = ((M1 > DLY_W) ? M1 : DLY_W) + 1;
    localparam logic [TW-1:0] PG_LAST   = TW'(PG_TMO - 1);
    localparam logic [TW-1:0] DONE_LAST = TW'(DONE_TMO - 1);

    seq_state_t         state_q, state_d;
    logic [N_RAILS-1:0] pg_s;
    logic               btn_s, done_s, press, all_pg, rails_on;
    logic [TW-1:0]      tmr;
    logic [TW:0]        tmr_p1, dly_ext;

    pwr_seq_sync #(.W(N_RAILS + 2)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d ({btn_raw, fpga_done, rail_pg}),
        .q ({btn_s, done_s, pg_s})
    );

    pwr_seq_debounce #(.CYC(DEB_CYC)) u_deb (
        .clk (clk),
        .rst_n (rst_n),
        .din (btn_s),
        .press (press)
    );

    pwr_seq_timer #(.W(TW)) u_tmr (
        .clk (clk),
        .rst_n (rst_n),
        .restart (state_d != state_q),
        .cnt (tmr)
    );

    assign all_pg  = &pg_s;
    assign tmr_p1  = {1'b0, tmr} + 1'b1;
    assign dly_ext = (TW + 1)'(flash_delay);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:    if (press) state_d = ST_RAMP;
            ST_RAMP: begin
                if (all_pg)              state_d = ST_FLASH;
                else if (tmr >= PG_LAST) state_d = ST_FAULT;
            end
            ST_FLASH: begin
                if (!all_pg)                state_d = ST_RAMP;
                else if (tmr_p1 >= dly_ext) state_d = ST_CONFIG;
            end
            ST_CONFIG: begin
                if (!all_pg)               state_d = ST_RAMP;
                else if (done_s)           state_d = ST_RUN;
                else if (tmr >= DONE_LAST) state_d = ST_FAULT;
            end
            ST_RUN:    if (!all_pg) state_d = ST_RAMP;
            ST_FAULT:  state_d = ST_FAULT;
            default:   state_d = ST_FAULT;
        endcase
    end

    always_comb begin
        rails_on   = 1'b0;
        fpga_rst_n = 1'b0;
        mcu_en     = 1'b0;
        fault      = 1'b0;
        unique case (state_q)
            ST_OFF:    ;
            ST_RAMP,
            ST_FLASH:  rails_on = 1'b1;
            ST_CONFIG: begin
                rails_on   = 1'b1;
                fpga_rst_n = 1'b1;
            end
            ST_RUN: begin
                rails_on   = 1'b1;
                fpga_rst_n = 1'b1;
                mcu_en     = 1'b1;
            end
            ST_FAULT:  fault = 1'b1;
            default:   fault = 1'b1;
        endcase
    end

    assign rail_en = {N_RAILS{rails_on}};
    assign fp_en   = rails_on & pg_s[FP_IDX];
    assign state_o = state_q;

    // R3: rails only come up after a qualified press
    a_r3_rails_need_press: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|rail_en) |-> $past(press));
    // R5: reset release only after every rail was good
    a_r5_release_needs_pg: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fpga_rst_n) |-> $past(all_pg));
    // R6: MCU only starts after DONE was seen
    a_r6_mcu_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mcu_en) |-> $past(done_s) && $past(fpga_rst_n));
    // R7: any rail loss after bring-up returns to the rail wait
    a_r7_brownout_ramp: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_FLASH || state_q == ST_CONFIG || state_q == ST_RUN) && !all_pg)
        |=> state_q == ST_RAMP);
    // R8: fault is sticky until reset
    a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault && rail_en == '0);
endmodule

// File: tb/pwr_seq_ctrl_test.sv
module pwr_seq_ctrl_test;
    localparam int NR  = 3;
    localparam int FPI = 1;
    localparam int DEB = 8;
    localparam int PGT = 60;
    localparam int DNT = 30;
    localparam int DLW = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           btn_raw = 1'b0;
    logic [NR-1:0]  rail_pg = '0;
    logic           fpga_done = 1'b0;
    logic [DLW-1:0] flash_delay = '0;
    logic [NR-1:0]  rail_en;
    logic           fp_en, fpga_rst_n, mcu_en, fault;
    logic [2:0]     state_o;

    int vectors = 0;
    int fails = 0;

    always #5 clk = ~clk;

    pwr_seq_ctrl #(
        .N_RAILS(NR), .FP_IDX(FPI), .DEB_CYC(DEB),
        .PG_TMO(PGT), .DONE_TMO(DNT), .DLY_W(DLW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw), .rail_pg(rail_pg),
        .fpga_done(fpga_done), .flash_delay(flash_delay), .rail_en(rail_en),
        .fp_en(fp_en), .fpga_rst_n(fpga_rst_n), .mcu_en(mcu_en),
        .fault(fault), .state_o(state_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        step(200000);
        fails++;
        $display("FAIL watchdog: got 1 expected 0");
        report();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 state", state_o, 0);
        chk("R1 rails", rail_en, 0);
        chk("R1 fpga_rst_n", fpga_rst_n, 0);
        chk("R1 mcu_en", mcu_en, 0);
        chk("R1 fp_en", fp_en, 0);
        chk("R1 fault", fault, 0);

        // R2: every pulse shorter than the window is ignored
        for (int len = 1; len < DEB; len++) begin
            btn_raw = 1'b1;
            step(len);
            btn_raw = 1'b0;
            step(DEB + 4);
            chk("R2 glitch", state_o, 0);
        end

        // R3: a held press lands exactly DEB+2 edges after the rise
        btn_raw = 1'b1;
        step(DEB + 1);
        chk("R2 window", state_o, 0);
        step(1);
        chk("R3 state", state_o, 1);
        chk("R3 rails", rail_en, 7);
        chk("R3 fpga_rst_n", fpga_rst_n, 0);
        btn_raw = 1'b0;
        step(DEB + 4);

        // R4: the front-panel enable follows the chosen rail after 2 edges
        rail_pg = 3'b010;
        step(1);
        chk("R4 fp early", fp_en, 0);
        step(1);
        chk("R4 fp on", fp_en, 1);
        chk("R4 state", state_o, 1);

        // R5/R7: sweep the flash delay, brown out from CONFIG each time
        for (int d = 0; d <= 6; d++) begin
            int deff;
            deff = (d == 0) ? 1 : d;
            flash_delay = DLW'(d);
            rail_pg = 3'b111;
            step(2);
            chk("R5 ramp", state_o, 1);
            step(1);
            chk("R5 flash", state_o, 2);
            if (deff > 1) begin
                step(deff - 1);
                chk("R5 hold", fpga_rst_n, 0);
                chk("R5 hold state", state_o, 2);
            end
            step(1);
            chk("R5 config", state_o, 3);
            chk("R5 release", fpga_rst_n, 1);
            rail_pg = 3'b110;
            step(2);
            chk("R7 late", state_o, 3);
            step(1);
            chk("R7 state", state_o, 1);
            chk("R7 rst", fpga_rst_n, 0);
            chk("R7 rails", rail_en, 7);
        end

        // R6
        flash_delay = 8'd2;
        rail_pg = 3'b111;
        step(5);
        chk("R5 config2", state_o, 3);
        fpga_done = 1'b1;
        step(2);
        chk("R6 early", mcu_en, 0);
        step(1);
        chk("R6 state", state_o, 4);
        chk("R6 mcu", mcu_en, 1);

        // R7 from RUN
        rail_pg = 3'b011;
        step(3);
        chk("R7 run state", state_o, 1);
        chk("R7 run mcu", mcu_en, 0);
        chk("R7 run rst", fpga_rst_n, 0);
        chk("R7 run rails", rail_en, 7);
        fpga_done = 1'b0;
        rail_pg = 3'b001;
        step(2);
        chk("R4 fp off", fp_en, 0);

        // R8: RAMP entered 2 edges ago; fault due at entry + PGT
        step(PGT - 3);
        chk("R8 before", state_o, 1);
        step(1);
        chk("R8 state", state_o, 5);
        chk("R8 rails", rail_en, 0);
        chk("R8 fault", fault, 1);
        chk("R8 rst", fpga_rst_n, 0);
        btn_raw = 1'b1;
        step(DEB + 4);
        btn_raw = 1'b0;
        chk("R8 press ignored", state_o, 5);
        chk("R8 rails stay off", rail_en, 0);

        // R9
        rst_n = 1'b0;
        rail_pg = '0;
        step(2);
        rst_n = 1'b1;
        step(1);
        btn_raw = 1'b1;
        step(DEB + 2);
        chk("R3 again", state_o, 1);
        btn_raw = 1'b0;
        flash_delay = 8'd1;
        rail_pg = 3'b111;
        step(4);
        chk("R9 config", state_o, 3);
        step(DNT - 1);
        chk("R9 before", state_o, 3);
        step(1);
        chk("R9 state", state_o, 5);
        chk("R9 fault", fault, 1);
        chk("R9 rails", rail_en, 0);

        report();
    end
endmodule